// File: doc/BRIEF.md
# Flash Program/Erase Write-Guard

This block sits between the command decoder of a serial NOR flash and the array sequencer. It decides whether a program or erase request may proceed. The protection fields of the status register feed it: a three-bit size code, a top/bottom anchor, a sector-granularity switch and an inversion switch. From these fields it derives one contiguous protected byte range over a 16 MB (24-bit) array and holds that range in registers. Each request carries a start address and a size class (page, 4 KB sector, 64 KB block or the whole chip). The block aligns the request, tests it against the protected range and returns a single allow/deny verdict. A denied request must be dropped whole by the sequencer. No part of it is executed.

The protected bounds are always visible on the ports for debug. Requests go through a three-state controller. `ST_IDLE` waits for a request and moves to `ST_CHECK` when `req_valid` is high. `ST_CHECK` always moves to `ST_DONE` after one cycle and registers the verdict. `ST_DONE` presents the verdict for one cycle and always returns to `ST_IDLE`.

Top module: `fpc_guard`

## Requirements
- R1: While reset is held, `resp_valid` is 0, `req_ready` is 1 and `prot_none` is 1.
- R2: With sector mode off (`cfg_sec`=0) and inversion off, size code k in 1..6 protects 2^(17+k) bytes (256 KB up to 8 MB), code 7 protects the whole array and code 0 protects nothing.
- R3: With sector mode on (`cfg_sec`=1) and inversion off, codes 1, 2, 3 and 4 protect 4, 8, 16 and 32 KB, codes 5 to 7 also protect 32 KB, and code 0 protects nothing.
- R4: With `cfg_tb`=0 the protected bytes of size S are [0, S-1]. With `cfg_tb`=1 they are [2^24-S, 2^24-1].
- R5: With `cfg_cmp`=1 the protected set is the complement of the set that R2 to R4 give. A full set becomes empty and an empty set becomes the whole array.
- R6: `prot_lo`/`prot_hi` give the inclusive protected bounds. `prot_none`=1 marks an empty set and forces both bounds to 0. The outputs follow a change of the fields one clock edge later and not before.
- R7: `req_size` encoding: 0 = 256-byte page, 1 = 4 KB sector, 2 = 64 KB block, 3 = whole chip. The address is aligned down to the unit before the test.
- R8: A request is denied (`resp_allow`=0) when any byte of its aligned range is protected. Otherwise it is allowed, including a range that ends just next to a protected bound.
- R9: A whole-chip request is allowed only when the protected set is empty.
- R10: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is then 0 for two cycles. `resp_valid` is high for exactly one cycle, starting one edge after the accepting edge. A `req_valid` raised while `req_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bp | input | 3 | Protected-size code |
| cfg_tb | input | 1 | Anchor: 0 bottom, 1 top |
| cfg_sec | input | 1 | Sector-granularity mode |
| cfg_cmp | input | 1 | Invert the protected set |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Request byte address |
| req_size | input | 2 | Request size class |
| req_ready | output | 1 | Controller idle, request can be taken |
| resp_valid | output | 1 | Verdict strobe |
| resp_allow | output | 1 | Verdict: 1 allowed, 0 dropped |
| prot_lo | output | 24 | Lowest protected byte |
| prot_hi | output | 24 | Highest protected byte |
| prot_none | output | 1 | Protected set is empty |

## Verification
The bench aims at the edges of the protected range: a page or unit that ends one byte below the lower bound, or starts right after the upper bound, must be allowed. A design with an off-by-one compare would deny those requests, or allow the ones that touch the bound. Unaligned addresses are used so that a design without alignment would test the wrong range. Saturated sector codes, inversion of the empty and full sets, and whole-chip requests catch designs that wrap sizes or invert the wrong way. A request held during the busy cycles shows whether a design answers twice.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        RQ_PAGE   = 2'd0,
        RQ_SECTOR = 2'd1,
        RQ_BLOCK  = 2'd2,
        RQ_CHIP   = 2'd3
    } req_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_DONE  = 2'd2
    } fsm_state_e;

    typedef struct packed {
        logic [2:0] code;
        logic       top;
        logic       fine;
        logic       inv;
    } prot_cfg_t;

endpackage

// File: rtl/fpc_region.sv
module fpc_region #(
    parameter int ADDR_W  = 24,
    parameter int FRAC_LG = 6,
    parameter int SECT_LG = 12,
    parameter int SEC_MAX = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  fpc_pkg::prot_cfg_t   cfg,
    output logic [ADDR_W-1:0]    prot_lo,
    output logic [ADDR_W-1:0]    prot_hi,
    output logic                 prot_none
);
    localparam int SW = ADDR_W + 1;
    localparam logic [SW-1:0] ONE  = SW'(1);
    localparam logic [SW-1:0] FULL = ONE << ADDR_W;
    localparam int CAP_LG = SECT_LG + SEC_MAX - 1;

    logic [SW-1:0]     base_sz;
    logic              base_none;
    logic              base_full;
    logic [ADDR_W-1:0] lo_w;
    logic [ADDR_W-1:0] hi_w;
    logic              none_w;
    int                sh;
    int                k;

    // size of the anchored region before inversion
    always_comb begin
        k  = int'(cfg.code);
        sh = 0;
        if (cfg.code == 3'd0) begin
            base_sz = '0;
        end else if (cfg.fine) begin
            if (k > SEC_MAX) k = SEC_MAX;
            sh      = SECT_LG + k - 1;
            base_sz = ONE << sh;
        end else if (cfg.code == 3'd7) begin
            base_sz = FULL;
        end else begin
            sh      = ADDR_W - FRAC_LG + k - 1;
            base_sz = ONE << sh;
        end
    end

    assign base_none = (base_sz == '0);
    assign base_full = (base_sz == FULL);

    // anchor and inversion
    always_comb begin
        lo_w   = '0;
        hi_w   = '0;
        none_w = 1'b0;
        if (!cfg.inv) begin
            if (base_none) begin
                none_w = 1'b1;
            end else if (cfg.top) begin
                lo_w = ADDR_W'(FULL - base_sz);
                hi_w = ADDR_W'(FULL - ONE);
            end else begin
                hi_w = ADDR_W'(base_sz - ONE);
            end
        end else begin
            if (base_full) begin
                none_w = 1'b1;
            end else if (base_none) begin
                hi_w = ADDR_W'(FULL - ONE);
            end else if (cfg.top) begin
                hi_w = ADDR_W'(FULL - base_sz - ONE);
            end else begin
                lo_w = ADDR_W'(base_sz);
                hi_w = ADDR_W'(FULL - ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_lo   <= '0;
            prot_hi   <= '0;
            prot_none <= 1'b1;
        end else begin
            prot_lo   <= lo_w;
            prot_hi   <= hi_w;
            prot_none <= none_w;
        end
    end

    AST_BOUNDS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_none |-> (prot_lo <= prot_hi)); // R6

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        prot_none |-> (prot_lo == '0 && prot_hi == '0)); // R6

    AST_SEC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg.fine && !cfg.inv) && !prot_none)
            |-> ((prot_hi - prot_lo) < (ADDR_W'(1) << CAP_LG))); // R3

endmodule

// File: rtl/fpc_align.sv
module fpc_align #(
    parameter int ADDR_W  = 24,
    parameter int PAGE_LG = 8,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16
) (
    input  logic [ADDR_W-1:0]   addr,
    input  fpc_pkg::req_size_e  size,
    output logic [ADDR_W-1:0]   rng_start,
    output logic [ADDR_W-1:0]   rng_end,
    output logic                is_chip
);
    localparam logic [ADDR_W-1:0] ONES = '1;

    logic [ADDR_W-1:0] mask;

    always_comb begin
        is_chip = 1'b0;
        unique case (size)
            fpc_pkg::RQ_PAGE:   mask = ONES << PAGE_LG;
            fpc_pkg::RQ_SECTOR: mask = ONES << SECT_LG;
            fpc_pkg::RQ_BLOCK:  mask = ONES << BLK_LG;
            default: begin
                mask    = '0;
                is_chip = 1'b1;
            end
        endcase
        rng_start = addr & mask;
        rng_end   = rng_start | ~mask;
    end

endmodule

// File: rtl/fpc_fsm.sv
module fpc_fsm #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_chip,
    input  logic [ADDR_W-1:0] rng_start,
    input  logic [ADDR_W-1:0] rng_end,
    input  logic [ADDR_W-1:0] prot_lo,
    input  logic [ADDR_W-1:0] prot_hi,
    input  logic              prot_none,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_allow
);
    import fpc_pkg::*;

    fsm_state_e        state_q, state_d;
    logic [ADDR_W-1:0] start_q, end_q;
    logic              chip_q;
    logic              allow_q;
    logic              hit;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign hit = !prot_none && (start_q <= prot_hi) && (end_q >= prot_lo);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            chip_q  <= 1'b0;
            allow_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                start_q <= rng_start;
                end_q   <= rng_end;
                chip_q  <= req_chip;
            end
            if (state_q == ST_CHECK) allow_q <= !hit;
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_DONE);
        resp_allow = (state_q == ST_DONE) && allow_q;
    end

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R10

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10

    AST_EMPTY_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && prot_none) |=> resp_allow); // R8

    AST_FULL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !prot_none && prot_lo == '0 && (&prot_hi))
            |=> (resp_valid && !resp_allow)); // R8

    AST_CHIP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && chip_q && !prot_none) |=> !resp_allow); // R9

endmodule

// File: rtl/fpc_guard.sv
module fpc_guard #(
    parameter int ADDR_W  = 24,
    parameter int FRAC_LG = 6,
    parameter int PAGE_LG = 8,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16,
    parameter int SEC_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_bp,
    input  logic              cfg_tb,
    input  logic              cfg_sec,
    input  logic              cfg_cmp,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi,
    output logic              prot_none
);
    import fpc_pkg::*;

    prot_cfg_t         cfg;
    logic [ADDR_W-1:0] rng_start, rng_end;
    logic              is_chip;

    assign cfg = '{code: cfg_bp, top: cfg_tb, fine: cfg_sec, inv: cfg_cmp};

    fpc_region #(
        .ADDR_W(ADDR_W), .FRAC_LG(FRAC_LG), .SECT_LG(SECT_LG), .SEC_MAX(SEC_MAX)
    ) region_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .prot_lo(prot_lo), .prot_hi(prot_hi), .prot_none(prot_none)
    );

    fpc_align #(
        .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)
    ) align_i (
        .addr(req_addr), .size(req_size_e'(req_size)),
        .rng_start(rng_start), .rng_end(rng_end), .is_chip(is_chip)
    );

    fpc_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(is_chip),
        .rng_start(rng_start), .rng_end(rng_end),
        .prot_lo(prot_lo), .prot_hi(prot_hi), .prot_none(prot_none),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_allow(resp_allow)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !resp_valid && prot_none)); // R1

endmodule

// File: tb/fpc_guard_tb.sv
`timescale 1ns/1ps
module fpc_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_bp;
    logic        cfg_tb, cfg_sec, cfg_cmp;
    logic        req_valid;
    logic [23:0] req_addr;
    logic [1:0]  req_size;
    logic        req_ready, resp_valid, resp_allow, prot_none;
    logic [23:0] prot_lo, prot_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fpc_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bp(cfg_bp), .cfg_tb(cfg_tb),
        .cfg_sec(cfg_sec), .cfg_cmp(cfg_cmp), .req_valid(req_valid),
        .req_addr(req_addr), .req_size(req_size), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_allow(resp_allow),
        .prot_lo(prot_lo), .prot_hi(prot_hi), .prot_none(prot_none)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // expected bounds from the requirement text
    task automatic model(input int bp, input bit tb, input bit sec, input bit cmp,
                         output bit none, output longint lo, output longint hi);
        longint full = 64'd1 << 24;
        longint s;
        if (bp == 0)       s = 0;
        else if (sec)      s = 64'd4096 << ((bp > 4 ? 4 : bp) - 1);
        else if (bp == 7)  s = full;
        else               s = 64'd1 << (17 + bp);
        none = 0; lo = 0; hi = 0;
        if (!cmp) begin
            if (s == 0) none = 1;
            else if (tb) begin lo = full - s; hi = full - 1; end
            else         begin lo = 0;        hi = s - 1;    end
        end else begin
            if (s == full)   none = 1;
            else if (s == 0) begin lo = 0; hi = full - 1; end
            else if (tb)     begin lo = 0; hi = full - s - 1; end
            else             begin lo = s; hi = full - 1; end
        end
    endtask

    task automatic set_cfg(input int bp, input bit tb, input bit sec, input bit cmp);
        @(negedge clk);
        cfg_bp = 3'(bp); cfg_tb = tb; cfg_sec = sec; cfg_cmp = cmp;
        @(negedge clk);
    endtask

    task automatic check_bounds(input string req, input int bp, input bit tb,
                                input bit sec, input bit cmp);
        bit n; longint lo, hi;
        set_cfg(bp, tb, sec, cmp);
        model(bp, tb, sec, cmp, n, lo, hi);
        chk({req, " none"}, prot_none, n);
        chk({req, " lo"}, prot_lo, lo);
        chk({req, " hi"}, prot_hi, hi);
    endtask

    task automatic do_req(input string req, input logic [23:0] a,
                          input logic [1:0] sz, input bit exp_allow);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk({req, " R10 busy"}, req_ready, 0);
        @(negedge clk);
        chk({req, " R10 strobe"}, resp_valid, 1);
        chk({req, " verdict"}, resp_allow, exp_allow);
        @(negedge clk);
        chk({req, " R10 strobe end"}, resp_valid, 0);
        chk({req, " R10 ready"}, req_ready, 1);
    endtask

    task automatic t_reset;
        rst_n = 0; req_valid = 0; req_addr = '0; req_size = '0;
        cfg_bp = 3'd3; cfg_tb = 0; cfg_sec = 0; cfg_cmp = 0;
        repeat (3) @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 prot_none", prot_none, 1);
        rst_n = 1;
    endtask

    task automatic t_block_sizes;
        for (int bp = 0; bp < 8; bp++) begin
            check_bounds("R2 R4 bottom", bp, 0, 0, 0);
            check_bounds("R2 R4 top", bp, 1, 0, 0);
        end
    endtask

    task automatic t_sector_sizes;
        for (int bp = 0; bp < 8; bp++) begin
            check_bounds("R3 bottom", bp, 0, 1, 0);
            check_bounds("R3 top", bp, 1, 1, 0);
        end
    endtask

    task automatic t_invert;
        for (int bp = 0; bp < 8; bp++) begin
            check_bounds("R5 blocks", bp, bp[0], 0, 1);
            check_bounds("R5 sectors", bp, bp[1], 1, 1);
        end
    endtask

    task automatic t_latency;
        set_cfg(0, 0, 0, 0);
        @(negedge clk);
        cfg_bp = 3'd2;
        #1;
        chk("R6 old value kept", prot_none, 1);
        @(negedge clk);
        chk("R6 updated none", prot_none, 0);
        chk("R6 updated hi", prot_hi, 24'h07FFFF);
    endtask

    task automatic t_req_bottom;
        set_cfg(1, 0, 0, 0);            // [0, 0x3FFFF]
        do_req("R8 page on bound", 24'h03FF10, 2'd0, 0);
        do_req("R8 page after bound", 24'h040000, 2'd0, 1);
        do_req("R7 unaligned page", 24'h0400FF, 2'd0, 1);
        do_req("R7 unaligned block", 24'h04FFFF, 2'd2, 1);
        do_req("R7 block across", 24'h03FFFF, 2'd2, 0);
        do_req("R7 sector aligned down", 24'h03FFFF, 2'd1, 0);
    endtask

    task automatic t_req_top_sector;
        set_cfg(2, 1, 1, 0);            // [0xFFE000, 0xFFFFFF]
        do_req("R8 sector below", 24'hFFDFFF, 2'd1, 1);
        do_req("R8 sector on bound", 24'hFFE000, 2'd1, 0);
        do_req("R8 block covering", 24'hFF0123, 2'd2, 0);
        do_req("R8 page below", 24'hFFDF00, 2'd0, 1);
    endtask

    task automatic t_req_invert;
        set_cfg(1, 0, 0, 1);            // [0x40000, 0xFFFFFF]
        do_req("R5 R8 kept window", 24'h03FF00, 2'd0, 1);
        do_req("R5 R8 inverted part", 24'h040000, 2'd0, 0);
    endtask

    task automatic t_chip;
        set_cfg(0, 0, 0, 0);
        do_req("R9 chip empty", 24'h123456, 2'd3, 1);
        set_cfg(1, 1, 1, 0);
        do_req("R9 chip one sector", 24'h000000, 2'd3, 0);
        set_cfg(7, 0, 0, 1);
        do_req("R9 R5 full inverted empty", 24'h000000, 2'd3, 1);
        set_cfg(0, 0, 0, 1);
        do_req("R5 R8 all protected", 24'h000000, 2'd0, 0);
    endtask

    task automatic t_busy;
        set_cfg(1, 0, 0, 0);
        @(negedge clk);
        req_valid = 1; req_addr = 24'h800000; req_size = 2'd0;
        @(posedge clk);
        @(negedge clk);
        req_addr = 24'h000000;          // held while busy: must be ignored
        chk("R10 busy hold", req_ready, 0);
        @(negedge clk);
        req_valid = 0;
        chk("R10 first strobe", resp_valid, 1);
        chk("R10 first verdict", resp_allow, 1);
        @(negedge clk);
        chk("R10 no second strobe a", resp_valid, 0);
        @(negedge clk);
        chk("R10 no second strobe b", resp_valid, 0);
        chk("R10 ready back", req_ready, 1);
    endtask

    initial begin
        t_reset();
        t_block_sizes();
        t_sector_sizes();
        t_invert();
        t_latency();
        t_req_bottom();
        t_req_top_sector();
        t_req_invert();
        t_chip();
        t_busy();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule